// File: doc/BRIEF.md
# Round-Robin Interleaved Multiply-Add Datapath

This block spreads a stream of multiply-add operations over several identical slow copies of the same datapath. Each operand word arrives as three packed unsigned fields `a`, `b` and `c`. The block returns `a*b + c`, one result for each accepted word. A one-hot phase ring hands each accepted slot to the next copy in turn. Because of this, a copy sees a new operand only once every `LANES` slots, and its combinational multiply-add has `LANES` fast cycles to settle. An output multiplexer, driven from the same phase ring, collects the copies' results in their original order into one full-rate output register. From outside, the block looks like a single pipelined datapath that accepts one word per clock.

Both data edges use a valid/ready handshake. The whole block moves forward one slot whenever the output register is empty or is being taken (`out_valid` low or `out_ready` high). In any other cycle every register is frozen, including the phase ring, and `in_ready` is low. `in_ready` therefore depends combinationally on `out_ready`. A slot in which `in_valid` is low still advances the ring. It carries a bubble that never reaches the output as a valid result.

Top module: `ilv_mac_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Each result equals `a*b + c`, computed on unsigned values and `2*W` bits wide. The input fields are `a = in_data[3W-1:2W]`, `b = in_data[2W-1:W]` and `c = in_data[W-1:0]`.
- R3: Results leave the block in the same order in which their operands were accepted. No result is lost and none is duplicated.
- R4: If `out_ready` stays high, a word accepted in cycle t is presented with `out_valid` high in cycle t+LANES+2.
- R5: With `in_valid` and `out_ready` held high, the block accepts a word and delivers a result in every cycle.
- R6: A slot with `in_valid` low produces no valid output. `out_valid` is never high unless an accepted word is still inside the block.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and in the next cycle `out_valid` stays high with `out_data` unchanged.
- R8: The phase ring is one-hot at all times. It moves one position per advancing slot, so each copy captures every LANES-th slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Block takes the word this cycle |
| in_data | input | 3*W | Packed {a, b, c} operands |
| out_valid | output | 1 | Result present in output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 2*W | Result a*b+c |

## Verification
The risky coincidence is a back-pressure freeze that lands in the same cycle as a copy's capture slot. In that cycle the copy has to keep both its old result and its new operand while the ring stands still. To provoke it, the bench drives a continuous input stream while a pseudo-random pattern toggles `out_ready`, so stalls fall on every phase position in turn. The scoreboard judges the outcome: every popped result must equal the queued reference in order, and a stalled output must stay unchanged until it is taken.

// File: rtl/ilv_mac_pkg.sv
package ilv_mac_pkg;
  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_W     = 8;
endpackage

// File: rtl/ilv_phase_ring.sv
module ilv_phase_ring #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [LANES-1:0] phase,
  output logic [LANES-1:0] sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= {{(LANES-1){1'b0}}, 1'b1};
    else if (adv) phase <= {phase[LANES-2:0], phase[LANES-1]};
  end

  // copy j's result is collected in the slot after its own capture slot
  always_comb begin
    for (int j = 0; j < LANES; j++) sel[j] = phase[(j + 1) % LANES];
  end

  a_r8_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(phase));
  a_r8_frozen_ring: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(phase));
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && phase[LANES-1]) |=> phase[0]);
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           in_vld,
  input  logic [3*W-1:0] in_word,
  output logic           res_vld,
  output logic [2*W-1:0] res
);
  localparam int unsigned RW = 2 * W;

  logic           opv_q;
  logic [3*W-1:0] op_q;
  logic [RW-1:0]  sum;

  // slow combinational path: has LANES fast cycles between captures
  always_comb begin
    sum = RW'(op_q[3*W-1:2*W]) * RW'(op_q[2*W-1:W]) + RW'(op_q[W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opv_q   <= 1'b0;
      op_q    <= '0;
      res_vld <= 1'b0;
      res     <= '0;
    end else if (en) begin
      res_vld <= opv_q;
      res     <= sum;
      opv_q   <= in_vld;
      op_q    <= in_word;
    end
  end

  a_r8_lane_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(op_q) && $stable(opv_q) && $stable(res) && $stable(res_vld)));
  a_r6_lane_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !opv_q) |=> !res_vld);
endmodule

// File: rtl/ilv_mac_top.sv
module ilv_mac_top #(
  parameter int unsigned LANES = ilv_mac_pkg::DEF_LANES,
  parameter int unsigned W     = ilv_mac_pkg::DEF_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [3*W-1:0] in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_data
);
  localparam int unsigned RW = 2 * W;
  localparam int unsigned CW = $clog2(LANES + 4) + 1;

  logic             adv;
  logic [LANES-1:0] phase, sel;
  logic [LANES-1:0] lane_vld;
  logic [RW-1:0]    lane_res [LANES];
  logic             mux_vld;
  logic [RW-1:0]    mux_res;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  ilv_phase_ring #(.LANES(LANES)) u_ring (
    .clk(clk), .rst_n(rst_n), .adv(adv), .phase(phase), .sel(sel)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ilv_lane #(.W(W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .en(adv && phase[k]),
      .in_vld(in_valid),
      .in_word(in_data),
      .res_vld(lane_vld[k]),
      .res(lane_res[k])
    );
  end

  always_comb begin
    mux_vld = 1'b0;
    mux_res = '0;
    for (int j = 0; j < LANES; j++) begin
      mux_vld = mux_vld | (sel[j] & lane_vld[j]);
      mux_res = mux_res | ({RW{sel[j]}} & lane_res[j]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= mux_vld;
      out_data  <= mux_res;
    end
  end

  // in-flight count, kept only for checking
  logic [CW-1:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + CW'(in_valid && in_ready) - CW'(out_valid && out_ready);
  end

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r7_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  a_r6_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight != '0));
  a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LANES + 2));
endmodule

// File: tb/ilv_mac_top_test.sv
module ilv_mac_top_test;
  localparam int N = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [3*W-1:0] in_data = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [2*W-1:0] out_data;

  ilv_mac_top #(.LANES(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, popped = 0;
  bit done = 1'b0;
  logic [2*W-1:0] exp_q[$];
  int             acc_q[$];
  bit             lat_q[$];
  bit             lat_mode = 1'b1;
  bit             was_stall = 1'b0;
  logic [2*W-1:0] held;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2*W-1:0] ref_mac(input logic [3*W-1:0] d);
    int unsigned a, b, c;
    a = d[3*W-1:2*W]; b = d[2*W-1:W]; c = d[W-1:0];
    return (2*W)'(a * b + c);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // driver: set inputs after the edge, record acceptance before the next edge
  task automatic drive(input bit v, input logic [3*W-1:0] d, input bit rdy);
    @(posedge clk); #1;
    in_valid = v; in_data = d; out_ready = rdy;
    @(negedge clk);
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_mac(d));
      acc_q.push_back(cyc);
      lat_q.push_back(lat_mode);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (was_stall)
        check(out_valid && out_data == held, "R7 hold", int'(out_data), int'(held));
      if (out_valid && !out_ready)
        check(!in_ready, "R7 in_ready", int'(in_ready), 0);
      was_stall = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 spurious output", int'(out_data), -1);
        end else begin
          automatic logic [2*W-1:0] e = exp_q.pop_front();
          automatic int a = acc_q.pop_front();
          automatic bit l = lat_q.pop_front();
          check(out_data == e, "R2/R3 value", int'(out_data), int'(e));
          if (l) check(cyc - a == N + 2, "R4 latency", cyc - a, N + 2);
          popped++;
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    int cnt;
    // R1 reset state
    #12;
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R5 back-to-back stream with corner operands, R2 extremes
    drive(1, {8'hFF, 8'hFF, 8'hFF}, 1);
    drive(1, {8'h00, 8'h00, 8'h00}, 1);
    drive(1, {8'h00, 8'hFF, 8'h7F}, 1);
    drive(1, {8'h80, 8'h02, 8'h01}, 1);
    for (int i = 0; i < 20; i++) drive(1, {8'(i*7+1), 8'(i*13+3), 8'(i)}, 1);
    cnt = popped;
    for (int i = 0; i < 8; i++) drive(1, {8'(i), 8'(i+1), 8'(i+2)}, 1);
    check(popped - cnt == 8, "R5 one result per cycle", popped - cnt, 8);

    // R6 bubbles: patterns of idle slots
    for (int i = 0; i < 24; i++) drive((i % 3) != 1, {8'(i+40), 8'(255-i), 8'(i*5)}, 1);
    for (int i = 0; i < 12; i++) drive(i == 5, {8'(i+9), 8'(i+3), 8'(i)}, 1);

    // R7 back-pressure at every phase position
    lat_mode = 1'b0;
    for (int i = 0; i < 200; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(1, {lf[7:0], lf[15:8], 8'(i)}, lf[0] | lf[3]);
    end
    for (int i = 0; i < 24; i++) drive(1, {8'(i), 8'(3), 8'(200)}, i % 5 == 0);

    // drain
    for (int i = 0; i < 4 * N; i++) drive(0, '0, 1);
    check(exp_q.size() == 0, "R3 nothing lost", exp_q.size(), 0);
    check(out_valid == 1'b0, "R6 idle after drain", int'(out_valid), 0);
    summary();
  end
endmodule